// File: doc/BRIEF.md
# Performance-State Boost Controller

This block picks the shared frequency/voltage operating point for a group of compute modules. Operating points form an ordered list of levels. A higher frequency level needs a voltage level at least as high. Levels 0 to `BASE_MAX` are the normal range. `ALL_BOOST` is a moderate boost that applies to every awake module. `MAX_BOOST` is a higher boost. It is allowed only while at least half of the modules sleep and software asks for the top point.

The controller follows the software request downward whenever the request allows a lower point. It climbs one level at a time, and only after the power and thermal headroom has lasted for a programmable number of evaluation ticks. Each voltage or frequency move goes through a one-step request/done handshake with the regulator and clock logic. A raise moves the voltage before the frequency. A lower moves the frequency before the voltage. A power or thermal limit pulls a boosted frequency down one level on every cycle the limit stays high, with no handshake, until the base maximum is reached. Each module reports the shared frequency level, or a parked index while it sleeps.

Top module: `boost_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `op_freq` and `op_volt` are 0 and `step_req` is 0.
- R2: `op_volt` is never below `op_freq`. To raise the frequency while the voltage is equal to it, the first step issued is a voltage step (`step_is_volt`=1) to one level higher.
- R3: To lower the level, the first step issued is a frequency step (`step_is_volt`=0) to one level lower. The voltage step down to the new frequency level follows it.
- R4: A request `perf_req` no greater than `BASE_MAX` (5) is the target level. The controller settles with `op_freq` and `op_volt` both equal to it.
- R5: A request above `BASE_MAX` with no limit active targets `ALL_BOOST` (6), unless R6 applies.
- R6: A request of at least `MAX_BOOST` (7), with at least half of the modules asleep (count×2 ≥ `N_MOD`) and no limit, targets `MAX_BOOST`. With fewer modules asleep the target is `ALL_BOOST`.
- R7: On each clock edge where `pwr_at_lim` or `tmp_at_lim` is high and `op_freq` > `BASE_MAX`, `op_freq` drops by exactly one and any step in flight is withdrawn. Once `op_freq` is `BASE_MAX`, the limit causes no further drop.
- R8: A boosted level is held, with no new step, for as long as the request and sleep status are unchanged and no limit is raised.
- R9: An upward step starts only after `eval_tick` has been seen `hyst_ticks` times with no limit. The count starts over when a limit is seen and when an upward step starts.
- R10: The `mod_lvl` field of each module (bits [4i+3:4i]) is 15 while `mod_asleep[i]` is high. Otherwise it equals `op_freq`.
- R11: A step request keeps its kind and level, and the levels do not move, until `step_done` is seen at a clock edge. The completed level shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perf_req | input | 4 | Requested operating level from software |
| pwr_at_lim | input | 1 | Power has reached its limit |
| tmp_at_lim | input | 1 | Temperature has reached its limit |
| mod_asleep | input | N_MOD | Deep-sleep status, one bit per module |
| eval_tick | input | 1 | Evaluation tick for headroom hysteresis |
| hyst_ticks | input | HYST_W | Ticks of headroom required before a climb |
| step_done | input | 1 | Regulator/clock step completed |
| step_req | output | 1 | A step is requested |
| step_is_volt | output | 1 | 1 = voltage step, 0 = frequency step |
| step_lvl | output | 4 | Destination level of the requested step |
| op_freq | output | 4 | Current shared frequency level |
| op_volt | output | 4 | Current voltage level |
| mod_lvl | output | N_MOD*4 | Per-module reported level |

## Verification
The hardest state to reach is a limit arriving while the controller sits at the highest boost with its voltage above the frequency and a step in flight. The throttle must then withdraw the step, fall exactly one level per cycle and stop at the base maximum. The stimulus gets there in three moves. It first parks half of the modules and asks for the top point, so the controller climbs to maximum boost. It then slows the handshake responder and holds a limit for several cycles. Last, it raises the hysteresis count while the limit is still high, so that the slow climb back is visible cycle by cycle.

// File: rtl/boost_pkg.sv
package boost_pkg;
    localparam int LVL_W = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t PARK_LVL = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_V_UP,
        ST_F_UP,
        ST_F_DN,
        ST_V_DN
    } seq_st_t;

    typedef struct packed {
        logic req;
        logic is_volt;
        lvl_t lvl;
    } step_t;

    function automatic lvl_t lvl_inc(input lvl_t l);
        return l + lvl_t'(1);
    endfunction

    function automatic lvl_t lvl_dec(input lvl_t l);
        return l - lvl_t'(1);
    endfunction
endpackage

// File: rtl/boost_target.sv
module boost_target
    import boost_pkg::*;
#(
    parameter int N_MOD     = 4,
    parameter int BASE_MAX  = 5,
    parameter int ALL_BOOST = 6,
    parameter int MAX_BOOST = 7
) (
    input  lvl_t             perf_req,
    input  logic             limit,
    input  logic [N_MOD-1:0] mod_asleep,
    output lvl_t             tgt
);
    int   n_sleep;
    logic half_asleep;

    always_comb begin
        n_sleep = 0;
        for (int i = 0; i < N_MOD; i++) begin
            n_sleep = n_sleep + int'(mod_asleep[i]);
        end
        half_asleep = (n_sleep * 2 >= N_MOD);
    end

    always_comb begin
        if (perf_req > lvl_t'(BASE_MAX)) begin
            if (limit)
                tgt = lvl_t'(BASE_MAX);
            else if (half_asleep && perf_req >= lvl_t'(MAX_BOOST))
                tgt = lvl_t'(MAX_BOOST);
            else
                tgt = lvl_t'(ALL_BOOST);
        end else begin
            tgt = perf_req;
        end
    end
endmodule

// File: rtl/boost_hyst.sv
module boost_hyst #(
    parameter int HYST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_tick,
    input  logic              limit,
    input  logic              consume,
    input  logic [HYST_W-1:0] hyst_ticks,
    output logic              climb_ok
);
    logic [HYST_W-1:0] streak;

    assign climb_ok = (streak >= hyst_ticks);

    always_ff @(posedge clk) begin
        if (rst)
            streak <= '0;
        else if (limit || consume)
            streak <= '0;
        else if (eval_tick && !climb_ok)
            streak <= streak + HYST_W'(1);
    end
endmodule

// File: rtl/boost_seq.sv
module boost_seq
    import boost_pkg::*;
#(
    parameter int BASE_MAX = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  lvl_t  tgt,
    input  logic  limit,
    input  logic  climb_ok,
    input  logic  step_done,
    output lvl_t  freq,
    output lvl_t  volt,
    output step_t step,
    output logic  climb_start
);
    localparam lvl_t BASE_L = lvl_t'(BASE_MAX);

    seq_st_t st;
    logic    throttle;
    logic    cancel_up;

    assign throttle    = limit && (freq > BASE_L);
    assign cancel_up   = limit && (freq >= BASE_L) && (st == ST_V_UP || st == ST_F_UP);
    assign climb_start = (st == ST_IDLE) && !throttle && (freq < tgt) && climb_ok;

    always_comb begin
        step = '0;
        unique case (st)
            ST_V_UP: step = '{req: 1'b1, is_volt: 1'b1, lvl: lvl_inc(freq)};
            ST_F_UP: step = '{req: 1'b1, is_volt: 1'b0, lvl: lvl_inc(freq)};
            ST_F_DN: step = '{req: 1'b1, is_volt: 1'b0, lvl: lvl_dec(freq)};
            ST_V_DN: step = '{req: 1'b1, is_volt: 1'b1, lvl: freq};
            default: step = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            freq <= '0;
            volt <= '0;
        end else if (throttle) begin
            freq <= lvl_dec(freq);
            st   <= ST_IDLE;
        end else if (cancel_up) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (climb_start)
                        st <= (volt > freq) ? ST_F_UP : ST_V_UP;
                    else if (freq > tgt)
                        st <= ST_F_DN;
                    else if (volt > freq)
                        st <= ST_V_DN;
                end
                ST_V_UP: if (step_done) begin
                    volt <= lvl_inc(freq);
                    st   <= ST_F_UP;
                end
                ST_F_UP: if (step_done) begin
                    freq <= lvl_inc(freq);
                    st   <= ST_IDLE;
                end
                ST_F_DN: if (step_done) begin
                    freq <= lvl_dec(freq);
                    st   <= ST_V_DN;
                end
                ST_V_DN: if (step_done) begin
                    volt <= freq;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl
    import boost_pkg::*;
#(
    parameter int N_MOD     = 4,
    parameter int HYST_W    = 8,
    parameter int BASE_MAX  = 5,
    parameter int ALL_BOOST = 6,
    parameter int MAX_BOOST = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LVL_W-1:0]         perf_req,
    input  logic                     pwr_at_lim,
    input  logic                     tmp_at_lim,
    input  logic [N_MOD-1:0]         mod_asleep,
    input  logic                     eval_tick,
    input  logic [HYST_W-1:0]        hyst_ticks,
    input  logic                     step_done,
    output logic                     step_req,
    output logic                     step_is_volt,
    output logic [LVL_W-1:0]         step_lvl,
    output logic [LVL_W-1:0]         op_freq,
    output logic [LVL_W-1:0]         op_volt,
    output logic [N_MOD*LVL_W-1:0]   mod_lvl
);
    logic  limit;
    lvl_t  tgt;
    logic  climb_ok;
    logic  climb_start;
    lvl_t  freq;
    lvl_t  volt;
    step_t step;

    assign limit = pwr_at_lim | tmp_at_lim;

    boost_target #(
        .N_MOD(N_MOD), .BASE_MAX(BASE_MAX),
        .ALL_BOOST(ALL_BOOST), .MAX_BOOST(MAX_BOOST)
    ) u_target (
        .perf_req(perf_req), .limit(limit),
        .mod_asleep(mod_asleep), .tgt(tgt)
    );

    boost_hyst #(.HYST_W(HYST_W)) u_hyst (
        .clk(clk), .rst(rst), .eval_tick(eval_tick), .limit(limit),
        .consume(climb_start), .hyst_ticks(hyst_ticks), .climb_ok(climb_ok)
    );

    boost_seq #(.BASE_MAX(BASE_MAX)) u_seq (
        .clk(clk), .rst(rst), .tgt(tgt), .limit(limit),
        .climb_ok(climb_ok), .step_done(step_done),
        .freq(freq), .volt(volt), .step(step), .climb_start(climb_start)
    );

    assign step_req     = step.req;
    assign step_is_volt = step.is_volt;
    assign step_lvl     = step.lvl;
    assign op_freq      = freq;
    assign op_volt      = volt;

    for (genvar g = 0; g < N_MOD; g++) begin : g_mod
        assign mod_lvl[g*LVL_W +: LVL_W] = mod_asleep[g] ? PARK_LVL : freq;
    end
endmodule

// File: rtl/boost_ctrl_chk.sv
module boost_ctrl_chk
    import boost_pkg::*;
#(
    parameter int N_MOD     = 4,
    parameter int BASE_MAX  = 5,
    parameter int MAX_BOOST = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [LVL_W-1:0]   perf_req,
    input logic               pwr_at_lim,
    input logic               tmp_at_lim,
    input logic [N_MOD-1:0]   mod_asleep,
    input logic               step_done,
    input logic               step_req,
    input logic               step_is_volt,
    input logic [LVL_W-1:0]   step_lvl,
    input logic [LVL_W-1:0]   op_freq,
    input logic [LVL_W-1:0]   op_volt
);
    logic lim;
    logic max_ok;
    assign lim    = pwr_at_lim | tmp_at_lim;
    assign max_ok = ($countones(mod_asleep) * 2 >= N_MOD) &&
                    (perf_req >= LVL_W'(MAX_BOOST)) && !lim;

    // R2
    p_volt_covers_freq_r2: assert property (@(posedge clk) disable iff (rst)
        op_volt >= op_freq);

    // R7
    p_throttle_one_level_r7: assert property (@(posedge clk) disable iff (rst)
        (lim && op_freq > LVL_W'(BASE_MAX)) |=> (op_freq == $past(op_freq) - LVL_W'(1)));

    // R11
    p_step_held_r11: assert property (@(posedge clk) disable iff (rst)
        (step_req && !step_done && !lim) |=>
            (step_req && $stable(step_lvl) && $stable(step_is_volt) &&
             $stable(op_freq) && $stable(op_volt)));

    // R6
    p_max_boost_gate_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_req) && step_lvl == LVL_W'(MAX_BOOST)) |-> $past(max_ok));

    // R5
    p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
        op_freq <= LVL_W'(MAX_BOOST));
endmodule

bind boost_ctrl boost_ctrl_chk #(
    .N_MOD(N_MOD), .BASE_MAX(BASE_MAX), .MAX_BOOST(MAX_BOOST)
) u_chk (.*);

// File: tb/tb_boost_ctrl.sv
module tb_boost_ctrl;
    localparam int N = 4;
    localparam int HW = 8;
    localparam int BASEL = 5;
    localparam int ALLB = 6;
    localparam int MAXB = 7;
    localparam int PARK = 15;

    logic          clk = 0;
    logic          rst = 1;
    logic [3:0]    perf_req = 0;
    logic          pwr_at_lim = 0;
    logic          tmp_at_lim = 0;
    logic [N-1:0]  mod_asleep = 0;
    logic          eval_tick = 0;
    logic [HW-1:0] hyst_ticks = 0;
    logic          step_done = 0;
    logic          step_req, step_is_volt;
    logic [3:0]    step_lvl, op_freq, op_volt;
    logic [N*4-1:0] mod_lvl;

    int n_chk = 0;
    int n_bad = 0;
    int ack_delay = 1;
    int ack_cnt = 0;
    int tick_per = 2;
    int tick_cnt = 0;
    bit finished = 0;

    // reference model state
    int m_f = 0, m_v = 0, m_st = 0, m_sk = 0;

    always #4 clk = ~clk;

    boost_ctrl #(.N_MOD(N), .HYST_W(HW), .BASE_MAX(BASEL),
                 .ALL_BOOST(ALLB), .MAX_BOOST(MAXB)) dut (
        .clk(clk), .rst(rst), .perf_req(perf_req), .pwr_at_lim(pwr_at_lim),
        .tmp_at_lim(tmp_at_lim), .mod_asleep(mod_asleep), .eval_tick(eval_tick),
        .hyst_ticks(hyst_ticks), .step_done(step_done), .step_req(step_req),
        .step_is_volt(step_is_volt), .step_lvl(step_lvl), .op_freq(op_freq),
        .op_volt(op_volt), .mod_lvl(mod_lvl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // regulator/clock responder
    always @(negedge clk) begin
        if (rst || !step_req || step_done) begin
            step_done <= 0;
            ack_cnt = 0;
        end else if (ack_cnt >= ack_delay) begin
            step_done <= 1;
            ack_cnt = 0;
        end else begin
            ack_cnt++;
        end
    end

    always @(negedge clk) begin
        tick_cnt++;
        eval_tick <= (tick_cnt % tick_per == 0);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_f = 0; m_v = 0; m_st = 0; m_sk = 0;
        end else begin
            bit lim, half, ok, up;
            int tg, ns;
            lim = pwr_at_lim | tmp_at_lim;
            ns = 0;
            for (int i = 0; i < N; i++) ns += int'(mod_asleep[i]);
            half = (ns * 2 >= N);
            if (perf_req > BASEL) tg = lim ? BASEL : ((half && perf_req >= MAXB) ? MAXB : ALLB);
            else tg = perf_req;
            ok = (m_sk >= hyst_ticks);
            up = 0;
            if (lim && m_f > BASEL) begin
                m_f--; m_st = 0;
            end else if (lim && m_f >= BASEL && (m_st == 1 || m_st == 2)) begin
                m_st = 0;
            end else begin
                case (m_st)
                    0: if (m_f < tg && ok) begin up = 1; m_st = (m_v > m_f) ? 2 : 1; end
                       else if (m_f > tg) m_st = 3;
                       else if (m_v > m_f) m_st = 4;
                    1: if (step_done) begin m_v = m_f + 1; m_st = 2; end
                    2: if (step_done) begin m_f++; m_st = 0; end
                    3: if (step_done) begin m_f--; m_st = 4; end
                    default: if (step_done) begin m_v = m_f; m_st = 0; end
                endcase
            end
            if (lim || up) m_sk = 0;
            else if (eval_tick && !ok) m_sk++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !finished) begin
            int e_lvl, e_ml;
            bit e_req, e_v;
            e_req = (m_st != 0);
            e_v = (m_st == 1 || m_st == 4);
            e_lvl = (m_st == 1 || m_st == 2) ? m_f + 1 : (m_st == 3 ? m_f - 1 : m_f);
            chk(op_freq == m_f, "model freq R4", op_freq, m_f);
            chk(op_volt == m_v, "model volt R2", op_volt, m_v);
            chk(step_req == e_req && (!e_req || (step_is_volt == e_v && step_lvl == e_lvl)),
                "model step R11", {step_req, step_is_volt, step_lvl},
                e_req ? {e_req, e_v, 4'(e_lvl)} : 0);
            e_ml = 0;
            for (int i = 0; i < N; i++)
                e_ml |= (mod_asleep[i] ? PARK : m_f) << (4 * i);
            chk(mod_lvl == e_ml, "model mod_lvl R10", mod_lvl, e_ml);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look();
        @(negedge clk);
        #2;
    endtask

    initial begin
        cyc(3);
        #2;
        chk(op_freq == 0 && op_volt == 0 && step_req == 0, "R1 in reset", {op_freq, op_volt}, 0);
        @(negedge clk); rst = 0;
        look();
        chk(op_freq == 0 && op_volt == 0 && step_req == 0, "R1 after reset", {step_req, op_freq, op_volt}, 0);

        // raise within base range: voltage first
        @(negedge clk); perf_req = 3;
        look();
        chk(step_req && step_is_volt && step_lvl == 1, "R2 voltage first", {step_req, step_is_volt, step_lvl}, {2'b11, 4'd1});
        cyc(60); #2;
        chk(op_freq == 3 && op_volt == 3, "R4 settle at 3", {op_freq, op_volt}, {4'd3, 4'd3});

        // lower: frequency first
        @(negedge clk); perf_req = 1;
        look();
        chk(step_req && !step_is_volt && step_lvl == 2, "R3 frequency first", {step_req, step_is_volt, step_lvl}, {2'b10, 4'd2});
        cyc(60); #2;
        chk(op_freq == 1 && op_volt == 1, "R3 settle at 1", {op_freq, op_volt}, {4'd1, 4'd1});

        // all-module boost
        @(negedge clk); perf_req = 9;
        cyc(80); #2;
        chk(op_freq == ALLB && op_volt == ALLB, "R5 all-module boost", op_freq, ALLB);
        cyc(50); #2;
        chk(op_freq == ALLB && step_req == 0, "R8 boost held", {step_req, op_freq}, ALLB);

        // maximum boost with half asleep, slow handshake
        @(negedge clk); ack_delay = 6; perf_req = 15; mod_asleep = 4'b0011;
        look();
        chk(step_req && step_is_volt && step_lvl == MAXB, "R6 climb to max starts", {step_req, step_is_volt, step_lvl}, {2'b11, 4'd7});
        cyc(3); #2;
        chk(step_req && step_lvl == MAXB && op_volt == ALLB, "R11 step held awaiting done", {step_req, op_volt}, {1'b1, 4'd6});
        cyc(60); #2;
        chk(op_freq == MAXB, "R6 max boost", op_freq, MAXB);
        chk(mod_lvl == {4'd7, 4'd7, 4'd15, 4'd15}, "R10 parked modules", mod_lvl, {4'd7, 4'd7, 4'd15, 4'd15});

        // fewer than half asleep: back to all-module boost
        @(negedge clk); ack_delay = 1; mod_asleep = 4'b0001;
        cyc(60); #2;
        chk(op_freq == ALLB, "R6 under half asleep", op_freq, ALLB);
        @(negedge clk); mod_asleep = 4'b0011;
        cyc(60); #2;
        chk(op_freq == MAXB, "R6 max boost again", op_freq, MAXB);

        // single-cycle limit
        @(negedge clk); pwr_at_lim = 1;
        @(negedge clk); pwr_at_lim = 0;
        #2;
        chk(op_freq == ALLB, "R7 one-level drop", op_freq, ALLB);
        cyc(40); #2;
        chk(op_freq == MAXB, "R7 recovered", op_freq, MAXB);

        // held limit, slow handshake
        @(negedge clk); ack_delay = 4; tmp_at_lim = 1;
        look();
        chk(op_freq == ALLB, "R7 held drop 1", op_freq, ALLB);
        look();
        chk(op_freq == BASEL, "R7 held drop 2", op_freq, BASEL);
        look();
        chk(op_freq == BASEL && !(step_req && !step_is_volt && step_lvl > BASEL), "R7 stop at base max", op_freq, BASEL);

        // hysteresis: climb back needs four ticks of headroom
        @(negedge clk); hyst_ticks = 4; tick_per = 3; ack_delay = 1;
        cyc(2);
        @(negedge clk); tmp_at_lim = 0;
        cyc(9); #2;
        chk(op_freq == BASEL, "R9 no climb before ticks", op_freq, BASEL);
        cyc(150); #2;
        chk(op_freq == MAXB, "R9 climb after ticks", op_freq, MAXB);

        // every module asleep
        @(negedge clk); mod_asleep = 4'b1111;
        look();
        chk(mod_lvl == 16'hFFFF, "R10 all parked", mod_lvl, 16'hFFFF);
        cyc(4);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule